// File: doc/BRIEF.md
# Ramp Timing Event Latch

This block turns two independent timing inputs into a single ramp timing state bit. One input sets the state and the other clears it. Each input takes one signal from a shared bank of candidate event sources, chosen by its own 4-bit select code. Each input also has its own inversion control and its own choice between edge and level detection. The selected source is treated as asynchronous. It passes through a synchroniser chain before detection.

The two conditioned events drive a set/clear state element in which clear always wins. If both inputs are active in the same cycle, the state is forced low. A blanking input from the neighbouring one-shot timer suppresses both inputs while it is high. An edge event that arrives during blanking is lost. A level that is still present when blanking drops takes effect in the first cycle after blanking ends. The state bit is the timing signal that downstream switch control uses to decide when the ramp runs.

Top module: `ramp_timing_latch`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state_o` becomes 0, and it reads 0 in the cycle after reset is released.
- R2: The set input is taken from `src_i[rise_sel]` and the clear input from `src_i[fall_sel]`. A select code of `NUM_SRC` or higher yields an input that is never active, whatever its inversion bit.
- R3: With an inversion bit at 1, that input is active on a low source; with it at 0, on a high source.
- R4: With a mode bit at 0 (level), that input is active in every cycle in which its synchronised, polarity-adjusted source is high.
- R5: With a mode bit at 1 (edge), that input is active for exactly one cycle per low-to-high transition of its synchronised, polarity-adjusted source; a source held high does not re-trigger.
- R6: Set active with clear inactive drives `state_o` to 1; clear active with set inactive drives it to 0; neither active keeps its value.
- R7: Set and clear active in the same cycle drive `state_o` to 0; one source feeding both inputs with equal polarity never makes `state_o` high.
- R8: An edge event occurring in a cycle with `blank_i` high is discarded and does not act later.
- R9: A level-mode input still active when `blank_i` falls takes effect at the first rising edge with `blank_i` low; while `blank_i` is high, `state_o` does not change.
- R10: A source change driven between clock edges reaches `state_o` at the third rising edge after it (two synchroniser stages plus the state register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Candidate asynchronous event sources |
| rise_sel | input | 4 | Source select for the set input |
| rise_inv | input | 1 | Invert the set source when 1 |
| rise_edge | input | 1 | Set input detection: 1 edge, 0 level |
| fall_sel | input | 4 | Source select for the clear input |
| fall_inv | input | 1 | Invert the clear source when 1 |
| fall_edge | input | 1 | Clear input detection: 1 edge, 0 level |
| blank_i | input | 1 | Blanking from the one-shot timer |
| state_o | output | 1 | Ramp timing state |

## Verification
The bench builds the block with `NUM_SRC` = 12 and `SYNC_STAGES` = 2. With 12 sources, select codes 12 to 15 are unused, so the never-active path is reachable from a 4-bit select. With two stages, the three-edge latency becomes a fixed, countable window. A behavioural model tracks each selected source through a delay queue and is compared with the block's output on every cycle. This is done across directed phases and across a long phase in which configuration, sources and blanking change at random, so both edges of blanking meet both detection modes.

// File: rtl/ramp_lat_pkg.sv
package ramp_lat_pkg;

    localparam int SEL_W   = 4;
    localparam int N_CHAN  = 2;
    localparam int CH_RISE = 0;
    localparam int CH_FALL = 1;

    typedef enum logic {
        DET_LEVEL = 1'b0,
        DET_EDGE  = 1'b1
    } det_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             inv;
        det_mode_e        mode;
    } chan_cfg_t;

    // Next value of the set/clear state: clear dominates set.
    function automatic logic sr_next(input logic cur, input logic set, input logic clr);
        logic nxt;
        if (clr)      nxt = 1'b0;
        else if (set) nxt = 1'b1;
        else          nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/rtl_chan_select.sv
module rtl_chan_select #(
    parameter int NUM_SRC = 12
) (
    input  logic [NUM_SRC-1:0]              src_i,
    input  logic [ramp_lat_pkg::SEL_W-1:0]  sel_i,
    input  logic                            inv_i,
    output logic                            raw_o
);
    // An unused code feeds the inversion value, so after polarity it is inactive.
    always_comb begin
        raw_o = inv_i;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(sel_i) == i) raw_o = src_i[i];
        end
    end
endmodule

// File: rtl/rtl_sync_chain.sv
module rtl_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg_q[0] <= 1'b0;
                    else     stg_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg_q[s] <= 1'b0;
                    else     stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rtl_event_detect.sv
module rtl_event_detect
    import ramp_lat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_i,
    input  logic      inv_i,
    input  det_mode_e mode_i,
    input  logic      blank_i,
    output logic      act_o
);
    logic pol;
    logic pol_prev_q;
    logic edge_hit;
    logic cand;

    assign pol = sync_i ^ inv_i;

    // Starts high so that no edge is seen in the first cycle out of reset.
    always_ff @(posedge clk) begin
        if (rst) pol_prev_q <= 1'b1;
        else     pol_prev_q <= pol;
    end

    assign edge_hit = pol & ~pol_prev_q;

    always_comb begin
        unique case (mode_i)
            DET_EDGE:  cand = edge_hit;
            default:   cand = pol;
        endcase
    end

    // Blanking drops edge hits outright; a level is simply still there later.
    assign act_o = cand & ~blank_i;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> !edge_hit); // R5
endmodule

// File: rtl/rtl_sr_core.sv
module rtl_sr_core
    import ramp_lat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic state_o
);
    logic state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= 1'b0;
        else     state_q <= sr_next(state_q, set_i, clr_i);
    end

    assign state_o = state_q;
endmodule

// File: rtl/ramp_timing_latch.sv
module ramp_timing_latch
    import ramp_lat_pkg::*;
#(
    parameter int NUM_SRC     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic [SEL_W-1:0]     rise_sel,
    input  logic                 rise_inv,
    input  logic                 rise_edge,
    input  logic [SEL_W-1:0]     fall_sel,
    input  logic                 fall_inv,
    input  logic                 fall_edge,
    input  logic                 blank_i,
    output logic                 state_o
);
    chan_cfg_t          cfg [N_CHAN];
    logic [N_CHAN-1:0]  raw;
    logic [N_CHAN-1:0]  synced;
    logic [N_CHAN-1:0]  act;

    assign cfg[CH_RISE] = '{sel: rise_sel, inv: rise_inv,
                            mode: rise_edge ? DET_EDGE : DET_LEVEL};
    assign cfg[CH_FALL] = '{sel: fall_sel, inv: fall_inv,
                            mode: fall_edge ? DET_EDGE : DET_LEVEL};

    generate
        for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
            rtl_chan_select #(.NUM_SRC(NUM_SRC)) u_sel (
                .src_i (src_i),
                .sel_i (cfg[c].sel),
                .inv_i (cfg[c].inv),
                .raw_o (raw[c])
            );
            rtl_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .d_i (raw[c]),
                .q_o (synced[c])
            );
            rtl_event_detect u_det (
                .clk     (clk),
                .rst     (rst),
                .sync_i  (synced[c]),
                .inv_i   (cfg[c].inv),
                .mode_i  (cfg[c].mode),
                .blank_i (blank_i),
                .act_o   (act[c])
            );
        end
    endgenerate

    rtl_sr_core u_core (
        .clk     (clk),
        .rst     (rst),
        .set_i   (act[CH_RISE]),
        .clr_i   (act[CH_FALL]),
        .state_o (state_o)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !state_o); // R1
    AST_SET_ONLY: assert property (@(posedge clk) disable iff (rst)
        act[CH_RISE] && !act[CH_FALL] |=> state_o); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !act[CH_RISE] && !act[CH_FALL] |=> $stable(state_o)); // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        act[CH_FALL] |=> !state_o); // R7
    AST_BLANK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        blank_i |=> $stable(state_o)); // R9
endmodule

// File: tb/ramp_timing_latch_tb.sv
`timescale 1ns/1ps
module ramp_timing_latch_tb;
    localparam int NSRC = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src = '0;
    logic [3:0]      rise_sel = 4'd3, fall_sel = 4'd5;
    logic            rise_inv = 1'b0, fall_inv = 1'b0;
    logic            rise_edge = 1'b0, fall_edge = 1'b0;
    logic            blank = 1'b0;
    logic            state;

    int    n_chk  = 0;
    int    n_fail = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    always #2 clk = ~clk;

    ramp_timing_latch #(.NUM_SRC(NSRC), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .src_i(src),
        .rise_sel(rise_sel), .rise_inv(rise_inv), .rise_edge(rise_edge),
        .fall_sel(fall_sel), .fall_inv(fall_inv), .fall_edge(fall_edge),
        .blank_i(blank), .state_o(state)
    );

    // ---------------- behavioural reference ----------------
    bit m_state;
    bit qr[$];
    bit qf[$];
    bit m_prev_r, m_prev_f;

    function automatic bit pick(input bit [3:0] s, input bit inv);
        if (s < NSRC) return src[s];
        return inv;   // inverted later to a permanent "inactive"
    endfunction

    always @(posedge clk) begin
        bit pr, pf, er, ef, ar, af;
        if (rst) begin
            m_state = 1'b0;
            qr = '{1'b0, 1'b0};
            qf = '{1'b0, 1'b0};
            m_prev_r = 1'b1;
            m_prev_f = 1'b1;
        end else begin
            pr = qr[qr.size()-2] ^ rise_inv;
            pf = qf[qf.size()-2] ^ fall_inv;
            qr.push_back(pick(rise_sel, rise_inv));
            qf.push_back(pick(fall_sel, fall_inv));
            if (qr.size() > 4) void'(qr.pop_front());
            if (qf.size() > 4) void'(qf.pop_front());
            er = pr && !m_prev_r;
            ef = pf && !m_prev_f;
            m_prev_r = pr;
            m_prev_f = pf;
            ar = (rise_edge ? er : pr) && !blank;
            af = (fall_edge ? ef : pf) && !blank;
            if (af)      m_state = 1'b0;
            else if (ar) m_state = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (state !== m_state) begin
                n_fail++;
                $display("FAIL %s: cycle compare state_o=%0b expected %0b", tag, state, m_state);
            end
        end
    end

    task automatic chk(input string t, input bit exp);
        n_chk++;
        if (state !== exp) begin
            n_fail++;
            $display("FAIL %s: state_o=%0b expected %0b", t, state, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        bit seen_high;
        cyc(3);
        chk("R1", 1'b0);
        rst = 1'b0;
        cyc(1);
        chk("R1", 1'b0);

        // R10 latency, R4/R6 level set
        tag = "R10";
        src[3] = 1'b1;
        @(posedge clk); @(posedge clk); #1 chk("R10", 1'b0);
        @(posedge clk); #1 chk("R10", 1'b1);
        @(negedge clk);
        src[3] = 1'b0;
        tag = "R6"; cyc(6); chk("R6", 1'b1);        // neither active: hold
        src[5] = 1'b1; cyc(4); chk("R6", 1'b0);      // clear only
        src[5] = 1'b0; cyc(4); chk("R6", 1'b0);

        // R7 both active; same source equal polarity
        tag = "R7";
        src[3] = 1'b1; cyc(4); chk("R4", 1'b1);
        src[5] = 1'b1; cyc(4); chk("R7", 1'b0);
        src[5] = 1'b0; src[3] = 1'b0; cyc(4);
        fall_sel = 4'd3;
        seen_high = 1'b0;
        for (int i = 0; i < 20; i++) begin
            src[3] = ~src[3];
            cyc(3);
            if (state) seen_high = 1'b1;
        end
        n_chk++;
        if (seen_high) begin n_fail++; $display("FAIL R7: state_o=1 expected 0"); end

        // R3: inverted clear on the same source gives pulses
        tag = "R3";
        src[3] = 1'b0; fall_inv = 1'b1; cyc(4); chk("R3", 1'b0);
        src[3] = 1'b1; cyc(4); chk("R3", 1'b1);
        src[3] = 1'b0; cyc(4); chk("R3", 1'b0);

        // R5: edge set, no re-trigger while held
        tag = "R5";
        fall_sel = 4'd5; fall_inv = 1'b0; rise_edge = 1'b1; cyc(3);
        src[3] = 1'b1; cyc(4); chk("R5", 1'b1);
        src[5] = 1'b1; cyc(4); src[5] = 1'b0; cyc(6); chk("R5", 1'b0);
        src[3] = 1'b0; cyc(4);

        // R8: edge during blanking discarded
        tag = "R8";
        blank = 1'b1; src[3] = 1'b1; cyc(6);
        blank = 1'b0; cyc(6); chk("R8", 1'b0);
        src[3] = 1'b0; cyc(4);

        // R9: level deferred until blanking ends
        tag = "R9";
        rise_edge = 1'b0; blank = 1'b1; src[3] = 1'b1; cyc(6); chk("R9", 1'b0);
        blank = 1'b0;
        @(posedge clk); #1 chk("R9", 1'b1);
        @(negedge clk);
        src[3] = 1'b0; src[5] = 1'b1; cyc(4); src[5] = 1'b0; cyc(3);

        // R2: unused select codes never act, either polarity
        tag = "R2";
        rise_sel = 4'd13; rise_inv = 1'b1; src = '1; cyc(6); chk("R2", 1'b0);
        rise_inv = 1'b0; src = '0; cyc(6); chk("R2", 1'b0);
        rise_sel = 4'd7; src[7] = 1'b1; cyc(4); chk("R2", 1'b1);
        fall_sel = 4'd15; fall_inv = 1'b1; cyc(6); chk("R2", 1'b1);

        // random mix over all features
        tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            if (i % 40 == 0) begin
                rise_sel = 4'($urandom_range(0, 15));
                fall_sel = 4'($urandom_range(0, 15));
                rise_inv = 1'($urandom); fall_inv = 1'($urandom);
                rise_edge = 1'($urandom); fall_edge = 1'($urandom);
            end
            src   = NSRC'($urandom);
            blank = ($urandom_range(0, 5) == 0);
            cyc(1);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        done = 1'b1;
        $display("FAIL watchdog: run hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule